// File: doc/BRIEF.md
# Video Frame Capture Sequencer

This block turns a stream of 8-bit video samples into one stored image. It watches the composite-sync and vertical-sync outputs of an external sync separator, finds where the active picture begins, and picks an evenly spaced grid of sample points. Each point becomes one write into an external SRAM. The columns are spread across the visible part of each line and the rows are spread across the visible lines. The clock is 10 MHz. The frame starts a fixed number of line periods after vertical sync falls. Each line starts a fixed number of cycles (9.5 µs) after composite sync falls. The visible part of a line lasts 524 cycles and the visible frame is 241 lines.

A mode input picks a coarse grid of 14 × 10 or a fine grid of 196 × 210. The block latches the mode when a capture starts. The column and row spacing is fractional, so two accumulators keep the spacing even. They still give exactly the grid count per line and per frame. Each write takes two cycles. In the first cycle the address and data registers are loaded. In the second cycle a registered strobe is raised. A row pulse marks every stored row. The host starts a capture by raising `enable`. The block answers with `done` and then ignores video until `enable` drops.

Top module: `vcap_frame_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `sram_we`, `row_inc`, `done` and `adc_oe` are low and `sram_addr` is 0.
- R2: Once armed, the block counts falling edges of `csync_in` that follow a falling edge of `vsync_in`. The first LINE_WAIT of these are skipped, and no write takes place on them. Active line 0 begins at the next edge after those.
- R3: Row k of a frame comes from active line ceil(k·ACT_LINES/ROWS), counting from line 0. No other active line produces a write.
- R4: On a captured line, the strobe for sample c is high in exactly one cycle. That cycle is PORCH_CYC + 6 + ceil(c·ACT_CYC/COLS) cycles after the cycle in which `csync_in` first reads low.
- R5: A captured line gives exactly COLS strobes, and each strobe lasts a single cycle.
- R6: Addresses start at 0 on every capture and go up by one per sample, row-major. Each capture writes ROWS·COLS addresses, and no write happens outside them.
- R7: `sram_data` during a strobe is the `adc_data` byte, unchanged, as it stood during that line.
- R8: `sram_addr` and `sram_data` hold the same value in the cycle before a strobe and during it.
- R9: `adc_oe` is high for exactly ACT_CYC cycles on each captured line and low on all other lines. It was high two cycles before every strobe.
- R10: `row_inc` pulses for one cycle once per stored row, which gives ROWS pulses per capture.
- R11: When `enable` is first seen high, `mode_large` is latched. A value of 0 selects SM_COLS × SM_ROWS and a value of 1 selects LG_COLS × LG_ROWS. Later changes to `mode_large` have no effect until the next capture.
- R12: `done` rises with the last `row_inc` and stays high while `enable` is high. Further syncs then cause no write, no `row_inc` and no `adc_oe`.
- R13: When `enable` is low, `done` clears on the next cycle and the block stays idle. Raising `enable` again starts a fresh capture that waits for the next vertical-sync fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | start/hold a capture; low returns to idle |
| mode_large | input | 1 | grid select, latched at start (0 coarse, 1 fine) |
| csync_in | input | 1 | composite sync from the separator, asynchronous |
| vsync_in | input | 1 | vertical sync from the separator, asynchronous |
| adc_data | input | 8 | converter output byte |
| adc_oe | output | 1 | converter output enable, high during a captured window |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_data | output | 8 | SRAM write data |
| sram_we | output | 1 | one-cycle write strobe |
| row_inc | output | 1 | one-cycle pulse per stored row |
| done | output | 1 | capture complete |

## Verification
The hardest case to reach is the fine grid. There, fractional spacing of under three cycles puts strobes back to back, and row selection skips lines in an irregular pattern. A fault in either accumulator shows up only as one sample landing a cycle early or one line chosen wrongly. The bench uses a shortened line and frame set by parameters. It drives whole frames of sync, and for every expected sample it queues the address, the byte, the line and the exact cycle offset from the line's sync fall. It also flips `mode_large` after arming, and runs a second frame after `done`, to show that both have no effect.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam int PIX_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SKIP,
        ST_LINE,
        ST_PORCH,
        ST_ACTIVE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic cs_fall;
        logic vs_fall;
    } sync_ev_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vcap_sync_edge.sv
module vcap_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic s1, s2, prev, fall_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1     <= 1'b1;
                s2     <= 1'b1;
                prev   <= 1'b1;
                fall_r <= 1'b0;
            end else begin
                s1     <= raw[i];
                s2     <= s1;
                prev   <= s2;
                fall_r <= prev & ~s2;
            end
        end
        assign fall[i] = fall_r;
    end
endmodule

// File: rtl/vcap_spacer.sv
module vcap_spacer #(
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [ACC_W-1:0] num,
    input  logic [ACC_W-1:0] den,
    output logic             fire
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   wrap;
    logic             hit;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, num};
        hit  = (sum >= {1'b0, den});
        wrap = sum - {1'b0, den};
        fire = adv & hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load) begin
            acc <= den - num;
        end else if (adv) begin
            acc <= hit ? wrap[ACC_W-1:0] : sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/vcap_wr_port.sv
module vcap_wr_port #(
    parameter int ADDR_W = 16,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              req,
    input  logic [DW-1:0]     pix,
    output logic [ADDR_W-1:0] addr,
    output logic [DW-1:0]     data,
    output logic              we
);
    logic [ADDR_W-1:0] next_addr;
    logic              pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_addr <= '0;
            addr      <= '0;
            data      <= '0;
            pend      <= 1'b0;
            we        <= 1'b0;
        end else if (clear) begin
            next_addr <= '0;
            pend      <= 1'b0;
            we        <= 1'b0;
        end else begin
            we <= pend;
            if (req) begin
                addr      <= next_addr;
                data      <= pix;
                next_addr <= next_addr + 1'b1;
                pend      <= 1'b1;
            end else begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vcap_frame_seq.sv
module vcap_frame_seq
    import vcap_pkg::*;
#(
    parameter int LINE_WAIT = 17,
    parameter int PORCH_CYC = 95,
    parameter int ACT_CYC   = 524,
    parameter int ACT_LINES = 241,
    parameter int SM_COLS   = 14,
    parameter int SM_ROWS   = 10,
    parameter int LG_COLS   = 196,
    parameter int LG_ROWS   = 210,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              mode_large,
    input  logic              csync_in,
    input  logic              vsync_in,
    input  logic [7:0]        adc_data,
    output logic              adc_oe,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_data,
    output logic              sram_we,
    output logic              row_inc,
    output logic              done
);
    localparam int CNT_W = bits_for(imax(imax(PORCH_CYC, ACT_CYC), LINE_WAIT) + 1);
    localparam int COL_W = bits_for(imax(ACT_CYC, LG_COLS) + 1);
    localparam int ROW_W = bits_for(imax(ACT_LINES, LG_ROWS) + 1);

    seq_state_e       state;
    sync_ev_t         ev;
    logic [1:0]       falls;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] rows;
    logic             large_q;
    logic [COL_W-1:0] ncols;
    logic [ROW_W-1:0] nrows;
    logic             row_fire, col_fire;
    logic             row_load, row_adv, col_load, col_adv, wr_clear;

    vcap_sync_edge #(.N(2)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .raw  ({csync_in, vsync_in}),
        .fall (falls)
    );
    assign ev.cs_fall = falls[1];
    assign ev.vs_fall = falls[0];

    assign ncols = large_q ? COL_W'(LG_COLS) : COL_W'(SM_COLS);
    assign nrows = large_q ? ROW_W'(LG_ROWS) : ROW_W'(SM_ROWS);

    assign row_load = (state == ST_IDLE) || (state == ST_ARM) || (state == ST_SKIP);
    assign row_adv  = (state == ST_LINE) && ev.cs_fall;
    assign col_load = (state == ST_PORCH);
    assign col_adv  = (state == ST_ACTIVE);
    assign wr_clear = (state == ST_IDLE) || (state == ST_ARM);

    vcap_spacer #(.ACC_W(ROW_W)) row_sp_i (
        .clk  (clk),
        .rst  (rst),
        .load (row_load),
        .adv  (row_adv),
        .num  (nrows),
        .den  (ROW_W'(ACT_LINES)),
        .fire (row_fire)
    );

    vcap_spacer #(.ACC_W(COL_W)) col_sp_i (
        .clk  (clk),
        .rst  (rst),
        .load (col_load),
        .adv  (col_adv),
        .num  (ncols),
        .den  (COL_W'(ACT_CYC)),
        .fire (col_fire)
    );

    vcap_wr_port #(.ADDR_W(ADDR_W), .DW(PIX_W)) wr_i (
        .clk   (clk),
        .rst   (rst),
        .clear (wr_clear),
        .req   (col_fire),
        .pix   (adc_data),
        .addr  (sram_addr),
        .data  (sram_data),
        .we    (sram_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rows    <= '0;
            large_q <= 1'b0;
            row_inc <= 1'b0;
        end else begin
            row_inc <= 1'b0;
            if (state != ST_IDLE && !enable) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (enable) begin
                        large_q <= mode_large;
                        state   <= ST_ARM;
                    end
                    ST_ARM: if (ev.vs_fall) begin
                        cnt   <= '0;
                        rows  <= '0;
                        state <= ST_SKIP;
                    end
                    ST_SKIP: if (ev.cs_fall) begin
                        if (cnt == CNT_W'(LINE_WAIT - 1)) state <= ST_LINE;
                        cnt <= cnt + 1'b1;
                    end
                    ST_LINE: if (row_fire) begin
                        cnt   <= '0;
                        state <= ST_PORCH;
                    end
                    ST_PORCH: begin
                        if (cnt == CNT_W'(PORCH_CYC - 1)) begin
                            cnt   <= '0;
                            state <= ST_ACTIVE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ACTIVE: begin
                        if (cnt == CNT_W'(ACT_CYC - 1)) begin
                            row_inc <= 1'b1;
                            rows    <= rows + 1'b1;
                            state   <= (rows == nrows - ROW_W'(1)) ? ST_DONE : ST_LINE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DONE: state <= ST_DONE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign adc_oe = (state == ST_ACTIVE);
    assign done   = (state == ST_DONE);

endmodule

// File: rtl/vcap_frame_seq_chk.sv
module vcap_frame_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              adc_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [7:0]        sram_data,
    input logic              sram_we,
    input logic              row_inc,
    input logic              done
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sram_we && !done && !row_inc && !adc_oe && sram_addr == '0));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
        sram_we |=> !sram_we);

    assert_wr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> ($stable(sram_addr) && $stable(sram_data)));

    assert_oe_before_we_R9: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> $past(adc_oe, 2));

    assert_row_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        row_inc |=> !row_inc);

    assert_done_idle_oe_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !adc_oe);

    assert_done_with_row_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> row_inc);

    assert_done_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (done && !enable) |=> !done);
endmodule

bind vcap_frame_seq vcap_frame_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .adc_oe    (adc_oe),
    .sram_addr (sram_addr),
    .sram_data (sram_data),
    .sram_we   (sram_we),
    .row_inc   (row_inc),
    .done      (done)
);

// File: tb/vcap_frame_seq_tb_top.sv
module vcap_frame_seq_tb_top;
    localparam int LW   = 3;
    localparam int PC   = 10;
    localparam int AC   = 60;
    localparam int LN   = 12;
    localparam int SM_C = 4;
    localparam int SM_R = 3;
    localparam int LG_C = 20;
    localparam int LG_R = 8;
    localparam int LP   = 90;
    localparam int LAT  = 6;

    typedef struct {
        int addr;
        int data;
        int off;
        int line;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        mode_large = 1'b0;
    logic        csync = 1'b1;
    logic        vsync = 1'b0;
    logic [7:0]  adc = 8'h00;
    logic        adc_oe;
    logic [15:0] sram_addr;
    logic [7:0]  sram_data;
    logic        sram_we;
    logic        row_inc;
    logic        done;

    int   n_checks = 0;
    int   n_fail   = 0;
    longint cyc = 0;
    longint fall_cyc = 0;
    int   line_id = 0;
    int   line_wr = 0;
    int   line_oe = 0;
    int   frame_rows = 0;
    int   prev_nw = 0;
    int   prev_noe = 0;
    bit   have_prev = 0;
    string prev_tag = "R2";
    logic [15:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vcap_frame_seq #(
        .LINE_WAIT (LW), .PORCH_CYC (PC), .ACT_CYC (AC), .ACT_LINES (LN),
        .SM_COLS (SM_C), .SM_ROWS (SM_R), .LG_COLS (LG_C), .LG_ROWS (LG_R),
        .ADDR_W (16)
    ) dut_i (
        .clk (clk), .rst (rst), .enable (enable), .mode_large (mode_large),
        .csync_in (csync), .vsync_in (vsync), .adc_data (adc),
        .adc_oe (adc_oe), .sram_addr (sram_addr), .sram_data (sram_data),
        .sram_we (sram_we), .row_inc (row_inc), .done (done)
    );

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (adc_oe) line_oe++;
            if (row_inc) frame_rows++;
            if (sram_we) begin
                line_wr++;
                chk(sram_addr == last_addr && sram_data == last_data, "R8",
                    "addr held before strobe", longint'(last_addr), longint'(sram_addr));
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "write with nothing expected", longint'(sram_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(sram_addr) == e.addr, "R6", "address", longint'(sram_addr), e.addr);
                    chk(int'(sram_data) == e.data, "R7", "data", longint'(sram_data), e.data);
                    chk(line_id == e.line, "R3", "captured line", line_id, e.line);
                    chk((cyc - fall_cyc) == e.off, "R4", "strobe offset", cyc - fall_cyc, e.off);
                end
            end
            last_addr <= sram_addr;
            last_data <= sram_data;
        end
    end

    task automatic check_prev();
        if (have_prev) begin
            chk(line_wr == prev_nw, prev_tag, "writes per line (R5)", line_wr, prev_nw);
            chk(line_oe == prev_noe, "R9", "adc_oe cycles per line", line_oe, prev_noe);
        end
        line_wr = 0;
        line_oe = 0;
    endtask

    task automatic drive_line(input logic [7:0] val, input int nw, input int noe, input string tag);
        @(negedge clk); #1;
        check_prev();
        prev_nw = nw; prev_noe = noe; prev_tag = tag; have_prev = 1;
        csync = 1'b0;
        adc = val;
        fall_cyc = cyc;
        line_id++;
        repeat (5) @(negedge clk);
        #1 csync = 1'b1;
        repeat (LP - 6) @(negedge clk);
    endtask

    task automatic run_frame(input bit lg, input bit live, input int base);
        int nc;
        int nr;
        int k;
        nc = lg ? LG_C : SM_C;
        nr = lg ? LG_R : SM_R;
        frame_rows = 0;
        @(negedge clk); #1 vsync = 1'b1;
        drive_line(8'h00, 0, 0, "R2");
        @(negedge clk); #1 vsync = 1'b0;
        repeat (10) @(negedge clk);
        for (int s = 0; s < LW; s++) drive_line(8'h00, 0, 0, "R2");
        for (int j = 0; j < LN; j++) begin
            k = -1;
            for (int r = 0; r < nr; r++) if (cdiv(r * LN, nr) == j) k = r;
            if (live && k >= 0) begin
                for (int c = 0; c < nc; c++)
                    exp_q.push_back('{addr: k * nc + c, data: (base + j) & 255,
                                      off: LAT + PC + cdiv(c * AC, nc), line: line_id + 1});
                drive_line(8'((base + j) & 255), nc, AC, "R3");
            end else begin
                drive_line(8'((base + j) & 255), 0, 0, live ? "R3" : "R12");
            end
        end
        drive_line(8'h00, 0, 0, "R3");
        @(negedge clk); #1;
        check_prev();
        have_prev = 0;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        chk(0, "R13", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!sram_we && !done && !row_inc && !adc_oe, "R1", "outputs in reset",
            {sram_we, done, row_inc, adc_oe}, 0);
        chk(sram_addr == 16'd0, "R1", "address in reset", longint'(sram_addr), 0);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !adc_oe, "R13", "idle while enable low", {done, adc_oe}, 0);

        // coarse grid capture
        #1 enable = 1'b1; mode_large = 1'b0;
        run_frame(0, 1, 8'h10);
        chk(done == 1'b1, "R12", "done after capture", done, 1);
        chk(frame_rows == SM_R, "R10", "row pulses coarse", frame_rows, SM_R);
        chk(exp_q.size() == 0, "R6", "all coarse writes seen", exp_q.size(), 0);

        // frame while done: ignored
        run_frame(0, 0, 8'h20);
        chk(done == 1'b1, "R12", "done held", done, 1);
        chk(frame_rows == 0, "R12", "no row pulses when done", frame_rows, 0);

        // release
        @(negedge clk); #1 enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R13", "done clears on enable low", done, 0);

        // fine grid, mode changed after arming
        #1 enable = 1'b1; mode_large = 1'b1;
        repeat (3) @(negedge clk);
        #1 mode_large = 1'b0;
        run_frame(1, 1, 8'h40);
        chk(frame_rows == LG_R, "R11", "row pulses fine", frame_rows, LG_R);
        chk(done == 1'b1, "R12", "done after fine", done, 1);
        chk(exp_q.size() == 0, "R6", "all fine writes seen", exp_q.size(), 0);

        // restart coarse: addresses from zero again
        @(negedge clk); #1 enable = 1'b0;
        repeat (2) @(negedge clk);
        #1 enable = 1'b1;
        run_frame(0, 1, 8'h80);
        chk(frame_rows == SM_R, "R13", "restart row pulses", frame_rows, SM_R);
        chk(exp_q.size() == 0, "R6", "restart writes seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule